// File: doc/BRIEF.md
# Configurable Memory Bank Mapper

This block sits between an 8-bit CPU with a 16-bit address bus and a wide external SRAM. On each memory access it takes the upper CPU address bits, picks a window, reads that window's page register and forms a wide physical address from the page number and the low address bits. A window can be 16K, 8K, 4K or 2K, so the 64K CPU space holds 4, 8, 16 or 32 windows. Each page register is 8 bits wide, so software can reach 256 chunks of the chosen size.

Software sets up the mapper with I/O writes. A control register sets the chunk size, turns on a whole-bank mode and turns the mapper on or off. An index register chooses which page register a data write changes. A bank register holds a 64K bank number. In whole-bank mode that one register replaces the entire 64K view in a single write, so the next instruction fetch already comes from the new bank. Every register can be read back through the same port, which lets context-switch code save the current mapping.

Top module: `bank_mapper`

## Requirements
- R1: After reset the chunk size is 16K, whole-bank mode is off, the mapper is on, the index and bank registers are 0, and page register i holds i. CPU address a then maps to physical address a.
- R2: The port responds only when cpu_addr[15] is 0 and cpu_addr[10] is 1. cpu_addr[9:8] selects the register: 0 is control, 1 is index, 2 is page data and 3 is bank.
- R3: The control register holds the chunk mode in bits [1:0] (0 is 16K, 1 is 8K, 2 is 4K, 3 is 2K), whole-bank mode in bit 2 and the mapper enable in bit 3. Its upper bits read back as 0.
- R4: A write to the page data register stores the data byte in the page register chosen by the index register. The index register keeps only data bits [4:0]. The new value is used from the clock edge that captures the write.
- R5: In 16K mode the physical address is page[a[15:14]] * 16384 + a[13:0].
- R6: In a chunk mode m with chunk size C = 16K >> m, the window number is a >> (14 - m). The physical address is page[window] * C + (a mod C).
- R7: In whole-bank mode the physical address is bank * 65536 + a, whatever the chunk mode. The bank register keeps data bits [5:0].
- R8: While io_rd is high and the port is decoded, rd_data returns the selected register. Otherwise rd_data is 0.
- R9: hit is high exactly when mem_req is high and the mapper is on.
- R10: An I/O write with cpu_addr[10] low, or with cpu_addr[15] high, changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_din | input | 8 | CPU data for I/O writes |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| mem_req | input | 1 | Memory access request |
| phys_addr | output | 22 | Translated SRAM address |
| hit | output | 1 | The mapper drives this memory access |
| rd_data | output | 8 | Register readback data |

## Verification
The bench works through all four chunk modes. For each mode it loads every window with its own page and sweeps the address space, so a wrong window-bit choice or a wrong offset width shows up as addresses that land in the wrong chunk or lose their low bits. It switches into whole-bank mode at banks 0, 5 and 63 and checks that the chunk mode has no effect there. It sends port accesses with A10 low or A15 high and then reads the registers back, which catches a decoder that accepts them. It also writes index values with the upper bits set, which catches a design that keeps too many bits.

// File: rtl/bank_mapper.sv
module bank_mapper #(
  parameter int PAGE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [15:0]           cpu_addr,
  input  logic [7:0]            cpu_din,
  input  logic                  io_wr,
  input  logic                  io_rd,
  input  logic                  mem_req,
  output logic [PAGE_W+13:0]    phys_addr,
  output logic                  hit,
  output logic [7:0]            rd_data
);
  localparam int PA_W   = PAGE_W + 14;
  localparam int BANK_W = PA_W - 16;
  localparam int WIN_W  = 5;
  localparam int NWIN   = 1 << WIN_W;

  logic [1:0]        mode_q;
  logic              whole_q, en_q;
  logic [WIN_W-1:0]  idx_q;
  logic [BANK_W-1:0] bank_q;
  logic [PAGE_W-1:0] page_q [NWIN];

  wire       port_hit = !cpu_addr[15] && cpu_addr[10];
  wire [1:0] rsel     = cpu_addr[9:8];
  wire       wr_en    = io_wr && port_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= 2'd0;
      whole_q <= 1'b0;
      en_q    <= 1'b1;
      idx_q   <= '0;
      bank_q  <= '0;
      for (int i = 0; i < NWIN; i++) page_q[i] <= PAGE_W'(i);
    end else if (wr_en) begin
      case (rsel)
        2'd0: begin
          mode_q  <= cpu_din[1:0];
          whole_q <= cpu_din[2];
          en_q    <= cpu_din[3];
        end
        2'd1: idx_q  <= cpu_din[WIN_W-1:0];
        2'd2: page_q[idx_q] <= cpu_din[PAGE_W-1:0];
        default: bank_q <= cpu_din[BANK_W-1:0];
      endcase
    end
  end

  wire [WIN_W-1:0]  win      = cpu_addr[15:11] >> (2'd3 - mode_q);
  wire [PAGE_W-1:0] page_sel = page_q[win];
  wire [3:0]        off_w    = 4'd14 - {2'b00, mode_q};
  wire [PA_W-1:0]   off_mask = (PA_W'(1) << off_w) - PA_W'(1);
  wire [PA_W-1:0]   chunk_pa = (PA_W'(page_sel) << off_w) | (PA_W'(cpu_addr) & off_mask);

  assign phys_addr = whole_q ? {bank_q, cpu_addr} : chunk_pa;
  assign hit       = mem_req && en_q;

  always_comb begin
    rd_data = 8'h00;
    if (io_rd && port_hit) begin
      case (rsel)
        2'd0:    rd_data = {4'b0000, en_q, whole_q, mode_q};
        2'd1:    rd_data = 8'(idx_q);
        2'd2:    rd_data = 8'(page_q[idx_q]);
        default: rd_data = 8'(bank_q);
      endcase
    end
  end

  assert_hit_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_req |-> !hit);

  assert_offset_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !whole_q |-> phys_addr[10:0] == cpu_addr[10:0]);

  assert_whole_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    whole_q |-> phys_addr[15:0] == cpu_addr);

  assert_decode_guard_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && (cpu_addr[15] || !cpu_addr[10])) |=>
      ($stable(mode_q) && $stable(whole_q) && $stable(en_q) && $stable(idx_q) && $stable(bank_q)));

  assert_page_store_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rsel == 2'd2) |=> page_q[$past(idx_q)] == $past(cpu_din[PAGE_W-1:0]));

  assert_rd_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rd |-> rd_data == 8'h00);
endmodule

// File: tb/test_bank_mapper.sv
module test_bank_mapper;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = 16'h0000;
  logic [7:0]  cpu_din = 8'h00;
  logic        io_wr = 1'b0, io_rd = 1'b0, mem_req = 1'b0;
  logic [21:0] phys_addr;
  logic        hit;
  logic [7:0]  rd_data;

  int checks = 0, failures = 0;
  bit done = 0;
  int ref_page [32];
  int ref_bank = 0;

  bank_mapper i_bank_mapper (.clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_din(cpu_din),
    .io_wr(io_wr), .io_rd(io_rd), .mem_req(mem_req), .phys_addr(phys_addr), .hit(hit), .rd_data(rd_data));

  always #5 clk = ~clk;

  task automatic chk(input longint act, input longint exp, input string req);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); cpu_addr = a; cpu_din = d; io_wr = 1'b1;
    @(negedge clk); io_wr = 1'b0;
  endtask

  task automatic reg_write(input int sel, input logic [7:0] d);
    io_write(16'h7C00 | 16'(sel << 8), d);
  endtask

  task automatic reg_read(input int sel, output logic [7:0] d);
    @(negedge clk); cpu_addr = 16'h7C00 | 16'(sel << 8); io_rd = 1'b1;
    #1 d = rd_data;
    io_rd = 1'b0;
  endtask

  function automatic longint exp_pa(input int mode, input bit whole, input int a);
    int sh = 14 - mode;
    if (whole) return longint'(ref_bank) * 65536 + a;
    return longint'(ref_page[a >> sh]) * (longint'(1) << sh) + (a % (1 << sh));
  endfunction

  task automatic sweep(input int mode, input bit whole, input int step, input string req);
    for (int a = 0; a < 65536; a += step) begin
      @(negedge clk); cpu_addr = 16'(a); mem_req = 1'b1;
      #1 chk(phys_addr, exp_pa(mode, whole, a), req);
    end
    mem_req = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    for (int i = 0; i < 32; i++) ref_page[i] = i;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: identity mapping and register defaults after reset
    reg_read(0, d); chk(d, 8'h08, "R1 ctrl");
    reg_read(1, d); chk(d, 0, "R1 index");
    reg_read(3, d); chk(d, 0, "R1 bank");
    sweep(0, 0, 4099, "R1 identity");

    // R9: hit gating
    @(negedge clk); mem_req = 1'b0; #1 chk(hit, 0, "R9 idle");
    mem_req = 1'b1; #1 chk(hit, 1, "R9 on");
    mem_req = 1'b0;

    // R8: no read strobe gives zero
    @(negedge clk); cpu_addr = 16'h7C00; #1 chk(rd_data, 0, "R8 no strobe");

    // R5/R6: every chunk mode with every window programmed
    for (int m = 0; m < 4; m++) begin
      reg_write(0, 8'(8 | m));
      reg_read(0, d); chk(d, 8 | m, "R3 ctrl readback");
      for (int w = 0; w < (4 << m); w++) begin
        ref_page[w] = (w * 37 + m * 11 + 3) & 255;
        reg_write(1, 8'(w));
        reg_write(2, 8'(ref_page[w]));
        reg_read(2, d); chk(d, ref_page[w], "R4 page readback");
      end
      sweep(m, 0, 97, m == 0 ? "R5 16K map" : "R6 small chunk map");
    end

    // R4: index keeps low five bits
    reg_write(1, 8'hE5); reg_read(1, d); chk(d, 8'h05, "R4 index mask");
    reg_read(2, d); chk(d, ref_page[5], "R4 masked index select");

    // R7: whole-bank mode, chunk mode left at 2K
    reg_write(0, 8'h0F);
    foreach (ref_bank_vals[k]) ;
    for (int k = 0; k < 3; k++) begin
      ref_bank = (k == 0) ? 0 : (k == 1) ? 5 : 63;
      reg_write(3, 8'(ref_bank | 8'hC0));
      reg_read(3, d); chk(d, ref_bank, "R7 bank mask");
      sweep(3, 1, 1021, "R7 whole bank");
    end

    // R10: writes outside the decode change nothing
    io_write(16'h7800, 8'h01);
    io_write(16'hFC00, 8'h02);
    reg_read(0, d); chk(d, 8'h0F, "R10 ctrl unchanged");
    io_write(16'h7900, 8'h09);
    io_write(16'hFD00, 8'h0A);
    reg_read(1, d); chk(d, 8'h05, "R10 index unchanged");
    io_write(16'h7A00, 8'h77);
    reg_read(2, d); chk(d, ref_page[5], "R10 page unchanged");
    io_write(16'h7B00, 8'h11);
    reg_read(3, d); chk(d, 63, "R10 bank unchanged");

    // R2: A10 low read gives nothing, decoded read works
    @(negedge clk); cpu_addr = 16'h7800; io_rd = 1'b1; #1 chk(rd_data, 0, "R2 A10 low read");
    io_rd = 1'b0;

    // R9/R3: mapper off
    reg_write(0, 8'h00);
    @(negedge clk); mem_req = 1'b1; #1 chk(hit, 0, "R9 disabled");
    mem_req = 1'b0;
    reg_read(0, d); chk(d, 0, "R3 ctrl off");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  int ref_bank_vals [1];
endmodule